// File: doc/BRIEF.md
# Pixel Group Hit Pointer Cell

This block is the storage of a single group of pixels in a column. When the group sees a hit, it keeps the hit data together with a short pointer into a timestamp table at the end of the column. It does not keep the full crossing number. The end of column drives a repeating three-phase broadcast: a latch phase, a readout phase and a release phase. Each phase carries a table address. The cell answers each phase by comparing that address with the pointers it holds.

In the latch phase a hit is written into a free slot together with the broadcast address, and the cell raises its got-hit line. The got-hit lines of all groups in a column are OR-ed so that the column allocates a table entry. In the readout phase a slot whose pointer equals a valid broadcast address is marked for transfer. Marked slots are then offered, one at a time, on a valid/ready readout port. In the release phase a slot whose pointer equals a valid broadcast address is erased. This is how a crossing that has aged out is forgotten. Hit data leaves the group only when it is triggered.

Top module: `pixgrp_ptr_cell`

## Requirements
- R1: After reset, every slot is empty and `got_hit`, `overflow` and `rd_valid` are all 0.
- R2: When `phase` is 1 (latch) and `hit_in` is 1 in a cycle, the lowest-index empty slot stores `bcast_addr` as its pointer and `hit_data` as its data. `got_hit` is 1 from the next cycle on.
- R3: A cycle with `hit_in` 0, or with `phase` other than 1, stores nothing.
- R4: A latch-phase hit that finds every slot occupied is dropped and sets `overflow`. `overflow` stays 1 until reset. A dropped hit does not raise `got_hit`.
- R5: When `phase` is 2 (readout) and `bcast_vld` is 1, every occupied slot whose pointer equals `bcast_addr` is marked for transfer. From the next cycle `rd_valid` is 1, with that slot's pointer on `rd_ptr` and its data on `rd_data`. A non-matching address marks nothing.
- R6: While `rd_ready` is 0, an offered slot stays offered with unchanged `rd_ptr` and `rd_data`. A cycle with `rd_valid` and `rd_ready` both 1 empties the offered slot.
- R7: When several slots are marked, they are offered in ascending slot index, one per accepted transfer.
- R8: When `phase` is 3 (release) and `bcast_vld` is 1, every occupied slot whose pointer equals `bcast_addr` is emptied, including a slot that is marked for transfer. Slots that do not match keep their contents.
- R9: A cycle with `phase` 3 leaves `got_hit` at 0 in the next cycle.
- R10: In phases 2 and 3, a cycle with `bcast_vld` 0 changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase | input | 2 | Broadcast phase: 0 idle, 1 latch, 2 readout, 3 release |
| bcast_addr | input | PTR_W | Table address broadcast by the end of column |
| bcast_vld | input | 1 | Address is meaningful in readout and release phases |
| hit_in | input | 1 | The group has a hit this cycle |
| hit_data | input | DATA_W | Hit payload to store |
| rd_ready | input | 1 | Column readout accepts the offered slot |
| rd_valid | output | 1 | A marked slot is offered |
| rd_ptr | output | PTR_W | Pointer of the offered slot |
| rd_data | output | DATA_W | Data of the offered slot |
| got_hit | output | 1 | Group line to be OR-ed across the column |
| overflow | output | 1 | Sticky flag for a dropped hit |

## Verification
The assertions assume that `phase` is always one of the four encodings and that `rd_ready` is only meaningful while `rd_valid` is 1. They also assume the readout port is not expected to keep the same offer during a readout or release phase, because a new lower-index mark or an erase can legitimately replace it. The stimulus drives only legal phase codes and holds `rd_ready` low across directed waits. The randomized section mixes all phases freely, including repeated pointers, releases of pending slots and full-group hits, and the bench's behavioural model predicts the outputs on every clock.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_LATCH   = 2'd1,
      PH_READOUT = 2'd2,
      PH_RELEASE = 2'd3
   } phase_e;
endpackage

// File: rtl/pgc_pick.sv
// Lowest-index selector: one-hot grant of the first set request bit.
module pgc_pick #(
   parameter int N = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   always_comb begin
      gnt = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (gnt == '0)) gnt[i] = 1'b1;
      end
   end
   assign any = |req;
endmodule

// File: rtl/pgc_slot.sv
// One storage slot: valid, transfer-pending mark, pointer and hit word.
module pgc_slot #(
   parameter int PTR_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PTR_W-1:0]  load_ptr,
   input  logic [DATA_W-1:0] load_data,
   input  logic [PTR_W-1:0]  bcast_addr,
   input  logic              arm,
   input  logic              drop,
   input  logic              accept,
   output logic              valid,
   output logic              pend,
   output logic [PTR_W-1:0]  ptr,
   output logic [DATA_W-1:0] data
);
   logic match;
   assign match = valid && (ptr == bcast_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         pend  <= 1'b0;
         ptr   <= '0;
         data  <= '0;
      end else if (drop && match) begin
         valid <= 1'b0;
         pend  <= 1'b0;
      end else if (accept) begin
         valid <= 1'b0;
         pend  <= 1'b0;
      end else if (arm && match) begin
         pend  <= 1'b1;
      end else if (load) begin
         valid <= 1'b1;
         pend  <= 1'b0;
         ptr   <= load_ptr;
         data  <= load_data;
      end
   end

   // R8
   release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && match) |=> !valid);
endmodule

// File: rtl/pixgrp_ptr_cell.sv
module pixgrp_ptr_cell
   import pgc_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int PTR_W     = 4,
   parameter int DATA_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        phase,
   input  logic [PTR_W-1:0]  bcast_addr,
   input  logic              bcast_vld,
   input  logic              hit_in,
   input  logic [DATA_W-1:0] hit_data,
   input  logic              rd_ready,
   output logic              rd_valid,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic [DATA_W-1:0] rd_data,
   output logic              got_hit,
   output logic              overflow
);
   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("pixgrp_ptr_cell: NUM_SLOTS must be at least 1");
   end
   if (PTR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pixgrp_ptr_cell: widths must be positive");
   end

   phase_e ph;
   assign ph = phase_e'(phase);

   logic                 lat_hit, arm, drop;
   logic [NUM_SLOTS-1:0] s_valid, s_pend, alloc_oh, rd_oh;
   logic                 free_any;
   logic [PTR_W-1:0]     s_ptr  [NUM_SLOTS];
   logic [DATA_W-1:0]    s_data [NUM_SLOTS];

   assign lat_hit = (ph == PH_LATCH) && hit_in;
   assign arm     = (ph == PH_READOUT) && bcast_vld;
   assign drop    = (ph == PH_RELEASE) && bcast_vld;

   pgc_pick #(.N(NUM_SLOTS)) u_free_pick (
      .req(~s_valid), .gnt(alloc_oh), .any(free_any));

   pgc_pick #(.N(NUM_SLOTS)) u_rd_pick (
      .req(s_valid & s_pend), .gnt(rd_oh), .any(rd_valid));

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      pgc_slot #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (lat_hit && alloc_oh[i]),
         .load_ptr  (bcast_addr),
         .load_data (hit_data),
         .bcast_addr(bcast_addr),
         .arm       (arm),
         .drop      (drop),
         .accept    (rd_oh[i] && rd_ready),
         .valid     (s_valid[i]),
         .pend      (s_pend[i]),
         .ptr       (s_ptr[i]),
         .data      (s_data[i]));
   end

   always_comb begin
      rd_ptr  = '0;
      rd_data = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (rd_oh[i]) begin
            rd_ptr  = rd_ptr  | s_ptr[i];
            rd_data = rd_data | s_data[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_hit  <= 1'b0;
         overflow <= 1'b0;
      end else begin
         if (ph == PH_RELEASE)         got_hit <= 1'b0;
         else if (lat_hit && free_any) got_hit <= 1'b1;
         if (lat_hit && !free_any)     overflow <= 1'b1;
      end
   end

   // R4
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R9
   gothit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_RELEASE) |=> !got_hit);

   // R2
   gothit_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_hit && free_any) |=> got_hit);

   // R6
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready && (ph == PH_IDLE || ph == PH_LATCH))
      |=> (rd_valid && $stable(rd_ptr) && $stable(rd_data)));
endmodule

// File: tb/tb_pixgrp_ptr_cell.sv
module tb_pixgrp_ptr_cell;
   localparam int NS = 2;
   localparam int PW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    phase = 2'd0;
   logic [PW-1:0] bcast_addr = '0;
   logic          bcast_vld = 1'b0;
   logic          hit_in = 1'b0;
   logic [DW-1:0] hit_data = '0;
   logic          rd_ready = 1'b0;
   logic          rd_valid, got_hit, overflow;
   logic [PW-1:0] rd_ptr;
   logic [DW-1:0] rd_data;

   always #5 clk = ~clk;

   pixgrp_ptr_cell #(.NUM_SLOTS(NS), .PTR_W(PW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .phase(phase), .bcast_addr(bcast_addr),
      .bcast_vld(bcast_vld), .hit_in(hit_in), .hit_data(hit_data),
      .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_ptr(rd_ptr),
      .rd_data(rd_data), .got_hit(got_hit), .overflow(overflow));

   // behavioural reference
   bit  mv [NS];
   bit  mp [NS];
   int  mptr [NS];
   int  mdat [NS];
   bit  mgot, movf;
   int  n_cmp = 0, n_bad = 0;
   string cur_req = "R1";
   bit  done = 1'b0;

   function automatic int sel_idx();
      for (int i = 0; i < NS; i++) if (mv[i] && mp[i]) return i;
      return -1;
   endfunction

   function automatic int free_idx();
      for (int i = 0; i < NS; i++) if (!mv[i]) return i;
      return -1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            mv[i] = 0; mp[i] = 0; mptr[i] = 0; mdat[i] = 0;
         end
         mgot = 0; movf = 0;
      end else begin
         int s, f;
         s = sel_idx();
         f = free_idx();
         for (int i = 0; i < NS; i++) begin
            if (mv[i]) begin
               if (phase == 3 && bcast_vld && mptr[i] == int'(bcast_addr)) begin
                  mv[i] = 0; mp[i] = 0;
               end else if (rd_ready && s == i) begin
                  mv[i] = 0; mp[i] = 0;
               end else if (phase == 2 && bcast_vld && mptr[i] == int'(bcast_addr)) begin
                  mp[i] = 1;
               end
            end
         end
         if (phase == 1 && hit_in) begin
            if (f >= 0) begin
               mv[f] = 1; mp[f] = 0; mptr[f] = int'(bcast_addr); mdat[f] = int'(hit_data);
            end else movf = 1;
         end
         if (phase == 3) mgot = 0;
         else if (phase == 1 && hit_in && f >= 0) mgot = 1;
      end
   end

   task automatic check(string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int s;
         s = sel_idx();
         check("got_hit", int'(got_hit), int'(mgot));
         check("overflow", int'(overflow), int'(movf));
         check("rd_valid", int'(rd_valid), (s >= 0) ? 1 : 0);
         if (s >= 0) begin
            check("rd_ptr", int'(rd_ptr), mptr[s]);
            check("rd_data", int'(rd_data), mdat[s]);
         end
      end
   end

   task automatic drive(input int ph, input int a, input bit v, input bit h,
                        input int d, input bit rdy);
      @(negedge clk);
      phase = 2'(ph); bcast_addr = PW'(a); bcast_vld = v;
      hit_in = h; hit_data = DW'(d); rd_ready = rdy;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      check("R1 rd_valid after reset", int'(rd_valid), 0);
      check("R1 got_hit after reset", int'(got_hit), 0);
      check("R1 overflow after reset", int'(overflow), 0);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R2";
      drive(1, 3, 0, 1, 8'hA5, 0);
      drive(1, 5, 0, 1, 8'h3C, 0);
      cur_req = "R3";
      drive(0, 6, 1, 1, 8'h11, 0);
      drive(1, 6, 0, 0, 8'h22, 0);
      drive(2, 6, 0, 1, 8'h33, 0);
      cur_req = "R4";
      drive(1, 7, 0, 1, 8'h77, 0);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R9";
      drive(3, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R5";
      drive(2, 9, 1, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R10";
      drive(2, 5, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R5";
      drive(2, 5, 1, 0, 0, 0);
      cur_req = "R6";
      drive(0, 0, 0, 0, 0, 0);
      drive(1, 8, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R10";
      drive(3, 3, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R8";
      drive(3, 3, 1, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R7";
      drive(1, 2, 0, 1, 8'h10, 0);
      drive(1, 2, 0, 1, 8'h20, 0);
      drive(2, 2, 1, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 1);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R8";
      drive(1, 4, 0, 1, 8'h44, 0);
      drive(2, 4, 1, 0, 0, 0);
      drive(3, 4, 1, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      cur_req = "R5";
      for (int k = 0; k < 2000; k++) begin
         drive(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
               1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
               int'($urandom_range(255, 0)), 1'($urandom_range(1, 0)));
      end
      drive(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      finish_run();
   end
endmodule